// File: doc/BRIEF.md
# Flash Memory Bus Interface Controller

This block sits between an on-chip CPU bus and a 16-bit flash array. It turns each CPU read or write request into the flash strobes: an active-low chip enable, an active-low output enable and an active-low write enable. Address and data pass straight through, bit for bit. Two strobe timings are available. In the fast one the chip enable goes low for the two strobe cycles right after the request is taken. In the slow, low-power one a run of settle cycles comes first, while the address and data lines stand still, and only then does the chip enable go low. The slow timing is meant for CPU clocks of 4 MHz or below.

A control/status register guards the flash and reports its state. A write-protect bit must be set before any write strobe can reach the array. While that bit is clear, a CPU write takes exactly as long as a real one but drives no strobe at all, so noise cannot start the flash's internal program or erase sequence. The ready/busy line from the array reads 0 while it is busy and 1 while it is ready or has an erase suspended. This line is asynchronous. It is synchronised, and each busy-to-ready edge sets a sticky ready flag. The interrupt output is the ready flag gated by an interrupt-enable bit. When software writes 0 to the ready flag, the flag and the enable are both cleared.

The CPU request side is a valid/ready channel. The CPU raises `cpu_valid` with stable `cpu_wr`, `cpu_addr` and `cpu_wdata`, and holds all of them until it sees `cpu_ready`. The access completes on the clock edge where both are high. `cpu_ready` is the only back-pressure: it stays low through the settle and strobe cycles, and the block takes a new request only after it has returned to idle.

Top module: `fbus_ctrl`

## Requirements
- R1: A request is accepted in idle. `cpu_ready` is high for exactly one cycle per request, in the last strobe cycle, and the transfer completes on that edge.
- R2: With the mode bit (register bit 2) at 0, `fl_ce_n` is low for exactly the two cycles that follow the idle cycle in which `cpu_valid` was seen.
- R3: With the mode bit at 1, `fl_ce_n` stays high for `WAIT_CYC` settle cycles after acceptance and then goes low for two cycles.
- R4: `fl_addr` equals `cpu_addr` and `fl_wdata` equals `cpu_wdata` at all times. During the ready cycle of a read, `cpu_rdata` equals `fl_rdata`.
- R5: A read drives `fl_oe_n` low in both strobe cycles and keeps `fl_we_n` high. A permitted write drives `fl_we_n` low in the second strobe cycle only and keeps `fl_oe_n` high.
- R6: With the write-protect bit (register bit 3) at 0, a write drives none of the three strobes low, and its `cpu_ready` arrives in the same cycle as it would for a permitted write.
- R7: Each 0-to-1 change of `fl_rdy` sets the ready flag (register bit 4) exactly three clock edges after the change, whatever the enable bit holds. A 1-to-0 change sets nothing. The synchroniser resets to ready.
- R8: `irq` is high exactly when both the ready flag and the interrupt enable (register bit 5) are 1.
- R9: A register write with bit 4 at 0 clears the ready flag and also clears the interrupt enable, whatever bit 5 of the written value holds. Writing 1 to bit 4 leaves the flag unchanged.
- R10: If a ready edge and a clearing write fall on the same clock edge, the ready flag ends up set. The enable is still cleared.
- R11: The register reads bits 7:6 and 1:0 as 0. Bits 5, 3 and 2 take the written value, and every bit resets to 0.
- R12: The mode and write-protect bits are sampled when a request is accepted. A change during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Request valid, held until `cpu_ready` |
| cpu_ready | output | 1 | Request completes on this cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Request address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid while `cpu_ready` is high on a read |
| csr_wr | input | 1 | Control/status register write strobe |
| csr_wdata | input | 8 | Register write value |
| csr_rdata | output | 8 | Register contents |
| irq | output | 1 | Interrupt request to the CPU |
| fl_addr | output | 16 | Flash address lines |
| fl_wdata | output | 16 | Flash write data lines |
| fl_rdata | input | 16 | Flash read data lines |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_rdy | input | 1 | Flash ready (1) / busy (0), asynchronous |

## Verification
The assertions assume that the CPU keeps `cpu_valid` high, with its request fields stable, from the idle cycle until `cpu_ready` has been seen. In particular, the check that the chip enable is only low under a live request depends on this. The bench meets that assumption by driving every request from one task, which drops `cpu_valid` only after the handshake edge. It changes `fl_rdy` and the register a quarter period after a falling edge, never at a rising edge, so the rising edges see stable inputs. Mode and protect changes made in the middle of an access are driven from a parallel branch that touches only the register pins.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int unsigned CSR_W    = 8;
  localparam int unsigned BIT_IEN  = 5;
  localparam int unsigned BIT_RFLG = 4;
  localparam int unsigned BIT_WPROT = 3;
  localparam int unsigned BIT_SLOW = 2;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_STB1   = 2'd2,
    PH_STB2   = 2'd3
  } fbc_phase_e;

  typedef struct packed {
    logic ien;
    logic rflg;
    logic wprot;
    logic slow;
  } fbc_csr_t;
endpackage

// File: rtl/fbc_rdy_edge.sv
module fbc_rdy_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_async,
  output logic rdy_rise
);
  localparam int unsigned CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  // Chain resets to "ready" so leaving reset never looks like an edge.
  genvar gi;
  generate
    for (gi = 0; gi < CHAIN; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b1;
          else        chain_q[gi] <= rdy_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b1;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign rdy_rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
endmodule

// File: rtl/fbc_csr.sv
module fbc_csr
  import fbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CSR_W-1:0] wdata,
  input  logic             set_rflg,
  output fbc_csr_t         regs,
  output logic [CSR_W-1:0] rdata
);
  logic clr_rflg;
  logic unused_bits;

  assign clr_rflg    = wr & ~wdata[BIT_RFLG];
  assign unused_bits = ^{wdata[CSR_W-1:BIT_IEN+1], wdata[BIT_SLOW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      if (wr) begin
        regs.ien   <= clr_rflg ? 1'b0 : wdata[BIT_IEN];
        regs.wprot <= wdata[BIT_WPROT];
        regs.slow  <= wdata[BIT_SLOW];
      end
      // A ready edge wins over a clearing write on the same edge.
      if (set_rflg)      regs.rflg <= 1'b1;
      else if (clr_rflg) regs.rflg <= 1'b0;
    end
  end

  always_comb begin
    rdata            = '0;
    rdata[BIT_IEN]   = regs.ien;
    rdata[BIT_RFLG]  = regs.rflg;
    rdata[BIT_WPROT] = regs.wprot;
    rdata[BIT_SLOW]  = regs.slow;
  end
endmodule

// File: rtl/fbc_strobe.sv
module fbc_strobe
  import fbc_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_wr,
  input  logic mode_slow,
  input  logic wr_permit,
  output logic req_ready,
  output logic ce_n,
  output logic oe_n,
  output logic we_n
);
  localparam int unsigned CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

  fbc_phase_e       phase_q;
  logic [CNT_W-1:0] wait_q;
  logic             wr_q;
  logic             blk_q;
  logic             strobing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wait_q  <= '0;
      wr_q    <= 1'b0;
      blk_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (req_valid) begin
          wr_q  <= req_wr;
          blk_q <= req_wr & ~wr_permit;
          if (mode_slow && WAIT_CYC > 0) begin
            phase_q <= PH_SETTLE;
            wait_q  <= CNT_W'(WAIT_CYC - 1);
          end else begin
            phase_q <= PH_STB1;
          end
        end
        PH_SETTLE: begin
          if (wait_q == '0) phase_q <= PH_STB1;
          else              wait_q  <= wait_q - 1'b1;
        end
        PH_STB1: phase_q <= PH_STB2;
        PH_STB2: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign strobing  = (phase_q == PH_STB1) || (phase_q == PH_STB2);
  assign req_ready = (phase_q == PH_STB2);
  assign ce_n      = ~(strobing & ~blk_q);
  assign oe_n      = ~(strobing & ~wr_q);
  assign we_n      = ~((phase_q == PH_STB2) & wr_q & ~blk_q);
endmodule

// File: rtl/fbus_ctrl.sv
module fbus_ctrl
  import fbc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned WAIT_CYC    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              csr_wr,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  csr_rdata,
  output logic              irq,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  input  logic [DATA_W-1:0] fl_rdata,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  input  logic              fl_rdy
);
  fbc_csr_t regs;
  logic     rdy_rise;

  assign fl_addr   = cpu_addr;
  assign fl_wdata  = cpu_wdata;
  assign cpu_rdata = fl_rdata;

  fbc_rdy_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .rdy_async (fl_rdy),
    .rdy_rise  (rdy_rise)
  );

  fbc_csr u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (csr_wr),
    .wdata    (csr_wdata),
    .set_rflg (rdy_rise),
    .regs     (regs),
    .rdata    (csr_rdata)
  );

  fbc_strobe #(.WAIT_CYC(WAIT_CYC)) u_stb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (cpu_valid),
    .req_wr    (cpu_wr),
    .mode_slow (regs.slow),
    .wr_permit (regs.wprot),
    .req_ready (cpu_ready),
    .ce_n      (fl_ce_n),
    .oe_n      (fl_oe_n),
    .we_n      (fl_we_n)
  );

  assign irq = regs.rflg & regs.ien;
endmodule

// File: rtl/fbc_checks.sv
module fbc_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_valid,
  input logic       cpu_ready,
  input logic       fl_ce_n,
  input logic       fl_oe_n,
  input logic       fl_we_n,
  input logic       csr_wr,
  input logic [7:0] csr_wdata,
  input logic [7:0] csr_rdata,
  input logic       irq
);
  assert_ready_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  assert_ce_under_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_ce_n |-> cpu_valid);

  assert_oe_we_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_oe_n && !fl_we_n));

  assert_we_inside_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (!fl_ce_n && cpu_ready));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (csr_rdata[5] && csr_rdata[4]));

  assert_clear_drops_ien_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !csr_wdata[4]) |=> !csr_rdata[5]);

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[7:6] == 2'b00 && csr_rdata[1:0] == 2'b00);
endmodule

bind fbus_ctrl fbc_checks u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_valid (cpu_valid),
  .cpu_ready (cpu_ready),
  .fl_ce_n   (fl_ce_n),
  .fl_oe_n   (fl_oe_n),
  .fl_we_n   (fl_we_n),
  .csr_wr    (csr_wr),
  .csr_wdata (csr_wdata),
  .csr_rdata (csr_rdata),
  .irq       (irq)
);

// File: tb/fbus_ctrl_tb.sv
module fbus_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = CLK_PERIOD / 4;
  localparam int W = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready;
  logic [15:0] cpu_rdata, fl_addr, fl_wdata, fl_rdata;
  logic        csr_wr = 1'b0;
  logic [7:0]  csr_wdata = '0, csr_rdata;
  logic        irq, fl_ce_n, fl_oe_n, fl_we_n;
  logic        fl_rdy = 1'b1;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // simple flash array model: data depends on address
  assign fl_rdata = fl_oe_n ? 16'h0000 : (fl_addr ^ 16'hA5C3);

  fbus_ctrl #(.WAIT_CYC(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .irq(irq), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n), .fl_rdy(fl_rdy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_ph = 0, m_len = 2;
  bit m_wr = 0, m_blk = 0, m_slow_acc = 0;
  bit m_ien = 0, m_rflg = 0, m_wprot = 0, m_slow = 0;
  int rdy_hist[$] = '{1, 1, 1};
  bit m_rise;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_ien = 0; m_rflg = 0; m_wprot = 0; m_slow = 0;
      rdy_hist = '{1, 1, 1};
    end else begin
      if (m_ph == 0) begin
        if (cpu_valid) begin
          m_wr = cpu_wr; m_blk = cpu_wr && !m_wprot; m_slow_acc = m_slow;
          m_len = (m_slow ? W : 0) + 2; m_ph = 1;
        end
      end else if (m_ph == m_len) m_ph = 0;
      else m_ph++;
      m_rise = (rdy_hist[1] == 1) && (rdy_hist[0] == 0);
      rdy_hist.push_back(int'(fl_rdy));
      void'(rdy_hist.pop_front());
      if (csr_wr) begin
        m_ien = csr_wdata[5]; m_wprot = csr_wdata[3]; m_slow = csr_wdata[2];
        if (!csr_wdata[4]) begin m_ien = 0; m_rflg = 0; end
      end
      if (m_rise) m_rflg = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit stb, rdy_e, ce_e, oe_e, we_e;
      logic [7:0] csr_e;
      stb   = (m_ph >= 1) && (m_ph >= m_len - 1);
      rdy_e = (m_ph >= 1) && (m_ph == m_len);
      ce_e  = !(stb && !m_blk);
      oe_e  = !(stb && !m_wr);
      we_e  = !(rdy_e && m_wr && !m_blk);
      csr_e = {2'b00, m_ien, m_rflg, m_wprot, m_slow, 2'b00};
      chk(cpu_ready == rdy_e, "R1 ready", cpu_ready, rdy_e);
      if (m_slow_acc) chk(fl_ce_n == ce_e, "R3 ce_n slow", fl_ce_n, ce_e);
      else            chk(fl_ce_n == ce_e, "R2 ce_n fast", fl_ce_n, ce_e);
      if (m_blk) chk({fl_oe_n, fl_we_n} == {oe_e, we_e}, "R6 blocked strobes",
                     {fl_oe_n, fl_we_n}, {oe_e, we_e});
      else       chk({fl_oe_n, fl_we_n} == {oe_e, we_e}, "R5 oe_n/we_n",
                     {fl_oe_n, fl_we_n}, {oe_e, we_e});
      chk(fl_addr == cpu_addr && fl_wdata == cpu_wdata, "R4 passthrough",
          {fl_addr, fl_wdata}, {cpu_addr, cpu_wdata});
      if (rdy_e && !m_wr)
        chk(cpu_rdata == (cpu_addr ^ 16'hA5C3), "R4 read data", cpu_rdata,
            cpu_addr ^ 16'hA5C3);
      chk(csr_rdata[4] == m_rflg, "R7 ready flag", csr_rdata[4], m_rflg);
      chk(csr_rdata[5] == m_ien, "R9 enable", csr_rdata[5], m_ien);
      chk(csr_rdata == csr_e, "R11 register", csr_rdata, csr_e);
      chk(irq == (m_ien && m_rflg), "R8 irq", irq, m_ien && m_rflg);
    end
  end

  // ---------------- stimulus ----------------
  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        output int n);
    @(negedge clk); #QTR;
    cpu_valid = 1; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    n = 0;
    forever begin
      @(negedge clk); #QTR; n++;
      if (cpu_ready || n > 50) break;
    end
    @(negedge clk); #QTR;
    cpu_valid = 0;
  endtask

  task automatic csr_put(input logic [7:0] v);
    @(negedge clk); #QTR;
    csr_wr = 1; csr_wdata = v;
    @(negedge clk); #QTR;
    csr_wr = 0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
    #QTR;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #1;
    chk(csr_rdata == 8'h00 && irq == 0, "R11 reset value", {csr_rdata, irq}, 0);
    chk({fl_ce_n, fl_oe_n, fl_we_n, cpu_ready} == 4'b1110, "R1 reset strobes",
        {fl_ce_n, fl_oe_n, fl_we_n, cpu_ready}, 4'b1110);
    #QTR; rst_n = 1;
    idle(2);

    // R6: protected write, no strobes, normal timing
    access(1, 16'h1234, 16'hBEEF, n);
    chk(n == 2, "R6 blocked write length", n, 2);
    // enable writes (bit4 written 1 to leave the flag alone)
    csr_put(8'h18);
    access(1, 16'h0F0F, 16'h5555, n);
    chk(n == 2, "R2 fast write length", n, 2);
    access(0, 16'h8001, 16'h0, n);
    chk(n == 2, "R1 fast read length", n, 2);
    access(0, 16'hFFFF, 16'h0, n);
    // R3: slow timing
    csr_put(8'h1C);
    access(0, 16'h4321, 16'h0, n);
    chk(n == W + 2, "R3 slow read length", n, W + 2);
    access(1, 16'h00AA, 16'hC0DE, n);
    chk(n == W + 2, "R3 slow write length", n, W + 2);
    // R12: switch to fast timing and protect while a slow access runs
    fork
      access(1, 16'h7777, 16'h1111, n);
      csr_put(8'h10);
    join
    chk(n == W + 2, "R12 latched mode", n, W + 2);
    access(1, 16'h2222, 16'h3333, n);
    chk(n == 2, "R12 new mode used", n, 2);

    // R7: ready edge with enable off sets flag, no irq
    fl_rdy = 0; idle(5);
    fl_rdy = 1; idle(2);
    chk(csr_rdata[4] == 0, "R7 not yet set", csr_rdata[4], 0);
    idle(1);
    chk(csr_rdata[4] == 1 && irq == 0, "R7 flag set, R8 no irq",
        {csr_rdata[4], irq}, 2'b10);
    // R8/R9: enable with bit4=1 keeps flag, irq rises
    csr_put(8'h38);
    chk(irq == 1, "R8 irq on", irq, 1);
    // R9: clear with bit5 written 1 still drops the enable
    csr_put(8'h28);
    chk(csr_rdata[5:4] == 2'b00 && irq == 0, "R9 clear", csr_rdata[5:4], 0);
    // busy edge must not set
    fl_rdy = 0; idle(6);
    chk(csr_rdata[4] == 0, "R7 falling edge ignored", csr_rdata[4], 0);

    // R10: sweep clearing write against the edge
    for (int off = 0; off < 5; off++) begin
      csr_put(8'h30);
      fl_rdy = 0; idle(6);
      fork
        begin fl_rdy = 1; end
        begin idle(off); csr_wr = 1; csr_wdata = 8'h20; idle(1); csr_wr = 0; end
      join
      idle(4);
      chk(csr_rdata[4] == m_rflg, "R10 set versus clear", csr_rdata[4], m_rflg);
      if (off == 2)
        chk(csr_rdata[5:4] == 2'b01, "R10 collision result", csr_rdata[5:4], 2'b01);
    end
    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule